// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This unit sits beside a small 8-bit CPU core and watches it while it runs. It compares the program counter against one programmed breakpoint address. It also watches three memory buses: the internal data memory bus, the special function register bus and the external data memory bus. Each bus has its own watchpoint. When any enabled comparator matches, the unit sets a sticky status bit for that source and raises a halt request. The debug controller acts on the halt request.

Each watchpoint is set up on its own. It can trigger on reads or on writes to one address. It can also require the byte that moves on the bus to equal a programmed value: the write data for writes, the read data for reads. Accesses that the debugger itself makes are flagged on an input, and they never trigger a comparator. So inspecting memory from the debug side cannot trip a watchpoint.

A 16-bit register port is used to program the comparators, to read back the configuration and the status, and to clear status bits. Writing a 1 to a status bit clears it. Two status outputs report whether the CPU is executing and whether a debugger access is in progress.

Top module: `dbg_watch_unit`

## Requirements
- R1: After an asynchronous reset, every register reads 0 and halt_req_o is low.
- R2: When the breakpoint is enabled (bit 0 of register 1), a cycle with pc_valid_i high and pc_i equal to register 0 sets status bit 0 at the next clock edge.
- R3: A watchpoint whose control register has bit 0 (enable) and bit 1 (write mode) set fires on any write strobe to its address. It ignores read strobes and writes to other addresses.
- R4: A watchpoint with enable set and bit 1 clear (read mode) fires on any read strobe to its address. It ignores write strobes.
- R5: With control bit 2 (data match) set, a match also needs the bus byte to equal the watchpoint's data register. The bus byte is wdata for write mode and rdata for read mode.
- R6: The external data watchpoint compares all 16 address bits. The internal data and function register address registers keep only their low 8 bits, and a readback of their upper bits returns 0.
- R7: A comparator whose enable bit is clear never sets its status bit.
- R8: No comparator fires in a cycle where dbg_acc_i is high.
- R9: Status bits hold until cleared. A write of 1 to a bit of register 11 clears that bit, and a write of 0 leaves it unchanged. If a new match and a clear hit the same bit in the same cycle, the bit stays set.
- R10: halt_req_o is high exactly when any status bit is set. The status bits are: bit 0 breakpoint, bit 1 internal data, bit 2 function register, bit 3 external data.
- R11: cpu_exec_o equals cpu_run_i while no halt is requested and is low during a halt request. dbg_busy_o is high whenever dbg_acc_i or reg_req_i is high.
- R12: The register map is as follows. Register 0 holds the breakpoint address and register 1 holds the breakpoint enable. The watchpoints sit at 2 to 4 (internal data), 5 to 7 (function register) and 8 to 10 (external data), in the order address, data, control, with control holding three bits. Register 11 is the status. Registers 12 to 15 read 0. reg_rdata_o shows the register selected by reg_addr_i combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_run_i | input | 1 | CPU is running an instruction |
| dbg_acc_i | input | 1 | Current bus access comes from the debugger |
| pc_i | input | 16 | Program counter |
| pc_valid_i | input | 1 | pc_i holds an instruction being executed |
| idm_addr_i | input | 8 | Internal data memory address |
| idm_wdata_i | input | 8 | Internal data memory write data |
| idm_rdata_i | input | 8 | Internal data memory read data |
| idm_we_i | input | 1 | Internal data memory write strobe |
| idm_re_i | input | 1 | Internal data memory read strobe |
| sfr_addr_i | input | 8 | Function register address |
| sfr_wdata_i | input | 8 | Function register write data |
| sfr_rdata_i | input | 8 | Function register read data |
| sfr_we_i | input | 1 | Function register write strobe |
| sfr_re_i | input | 1 | Function register read strobe |
| xdm_addr_i | input | 16 | External data memory address |
| xdm_wdata_i | input | 8 | External data memory write data |
| xdm_rdata_i | input | 8 | External data memory read data |
| xdm_we_i | input | 1 | External data memory write strobe |
| xdm_re_i | input | 1 | External data memory read strobe |
| reg_req_i | input | 1 | Register port access |
| reg_we_i | input | 1 | Register port write (else read) |
| reg_addr_i | input | 4 | Register index |
| reg_wdata_i | input | 16 | Register write data |
| reg_rdata_o | output | 16 | Register read data |
| halt_req_o | output | 1 | Halt request, OR of the status bits |
| cpu_exec_o | output | 1 | CPU executing and not halted |
| dbg_busy_o | output | 1 | Debugger access in progress |

## Verification
The hardest case to reach is a collision: a new match on a bus lands in the same clock cycle as a software write that clears that same status bit. The clear must lose, and the status bit must stay set. The stimulus drives both in one cycle on purpose. It also drives matching accesses while dbg_acc_i is high, and sends near-miss addresses and data to every watchpoint in both read and write mode. A randomized phase then mixes bus traffic, clears and reconfiguration, and a behavioural model of the register file checks the outputs every cycle.

// File: rtl/dbg_watch_pkg.sv
package dbg_watch_pkg;
  localparam int NWP    = 3;
  localparam int NSRC   = NWP + 1;
  localparam int WP_IDM = 0;
  localparam int WP_SFR = 1;
  localparam int WP_XDM = 2;

  localparam int REG_AW = 4;
  localparam int REG_DW = 16;

  localparam int REG_PC_ADDR = 0;
  localparam int REG_PC_CTRL = 1;
  localparam int REG_WP_BASE = 2;
  localparam int REG_WP_STEP = 3;
  localparam int REG_STAT    = 11;

  // bit 0 enable, bit 1 write mode, bit 2 data match
  typedef struct packed {
    logic dmatch;
    logic wr;
    logic en;
  } wp_ctrl_t;
endpackage

// File: rtl/dbg_pc_cmp.sv
module dbg_pc_cmp #(
  parameter int PC_W = 16
) (
  input  logic [PC_W-1:0] cfg_addr_i,
  input  logic            cfg_en_i,
  input  logic            suppress_i,
  input  logic [PC_W-1:0] pc_i,
  input  logic            pc_valid_i,
  output logic            hit_o
);
  assign hit_o = cfg_en_i & ~suppress_i & pc_valid_i & (pc_i == cfg_addr_i);
endmodule

// File: rtl/dbg_wp_cmp.sv
module dbg_wp_cmp
  import dbg_watch_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic [AW-1:0] cfg_addr_i,
  input  logic [DW-1:0] cfg_data_i,
  input  wp_ctrl_t      cfg_i,
  input  logic          suppress_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  input  logic [DW-1:0] bus_rdata_i,
  input  logic          bus_we_i,
  input  logic          bus_re_i,
  output logic          hit_o
);
  logic          strobe;
  logic [DW-1:0] seen;
  logic          data_ok;

  assign strobe  = cfg_i.wr ? bus_we_i    : bus_re_i;
  assign seen    = cfg_i.wr ? bus_wdata_i : bus_rdata_i;
  assign data_ok = ~cfg_i.dmatch | (seen == cfg_data_i);
  assign hit_o   = cfg_i.en & ~suppress_i & strobe & data_ok & (bus_addr_i == cfg_addr_i);
endmodule

// File: rtl/dbg_wp_regs.sv
module dbg_wp_regs
  import dbg_watch_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int IDM_AW = 8,
  parameter int SFR_AW = 8,
  parameter int XDM_AW = 16,
  parameter int DW     = 8,
  parameter int MAX_AW = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         reg_req_i,
  input  logic                         reg_we_i,
  input  logic [REG_AW-1:0]            reg_addr_i,
  input  logic [REG_DW-1:0]            reg_wdata_i,
  output logic [REG_DW-1:0]            reg_rdata_o,
  input  logic [NSRC-1:0]              src_hit_i,
  output logic [PC_W-1:0]              pc_addr_o,
  output logic                         pc_en_o,
  output logic [NWP-1:0][MAX_AW-1:0]   wp_addr_o,
  output logic [NWP-1:0][DW-1:0]       wp_data_o,
  output wp_ctrl_t [NWP-1:0]           wp_ctrl_o,
  output logic [NSRC-1:0]              status_o
);
  function automatic logic [MAX_AW-1:0] aw_mask(int idx);
    int w;
    logic [MAX_AW-1:0] m;
    w = (idx == WP_XDM) ? XDM_AW : ((idx == WP_SFR) ? SFR_AW : IDM_AW);
    m = '0;
    for (int b = 0; b < MAX_AW; b++) if (b < w) m[b] = 1'b1;
    return m;
  endfunction

  function automatic logic [REG_AW-1:0] wp_reg(int idx, int field);
    return REG_AW'(REG_WP_BASE + REG_WP_STEP * idx + field);
  endfunction

  logic                       wr;
  logic [NSRC-1:0]            clr;
  logic [NSRC-1:0]            status_d, status_q;
  logic [PC_W-1:0]            pc_addr_q;
  logic                       pc_en_q;
  logic [NWP-1:0][MAX_AW-1:0] wp_addr_q;
  logic [NWP-1:0][DW-1:0]     wp_data_q;
  wp_ctrl_t [NWP-1:0]         wp_ctrl_q;

  assign wr       = reg_req_i & reg_we_i;
  assign clr      = (wr && reg_addr_i == REG_AW'(REG_STAT)) ? reg_wdata_i[NSRC-1:0] : '0;
  assign status_d = (status_q & ~clr) | src_hit_i;  // new match beats clear

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_addr_q <= '0;
      pc_en_q   <= 1'b0;
      wp_addr_q <= '0;
      wp_data_q <= '0;
      wp_ctrl_q <= '0;
      status_q  <= '0;
    end else begin
      if (wr && reg_addr_i == REG_AW'(REG_PC_ADDR)) pc_addr_q <= reg_wdata_i[PC_W-1:0];
      if (wr && reg_addr_i == REG_AW'(REG_PC_CTRL)) pc_en_q   <= reg_wdata_i[0];
      for (int i = 0; i < NWP; i++) begin
        if (wr && reg_addr_i == wp_reg(i, 0)) wp_addr_q[i] <= reg_wdata_i[MAX_AW-1:0] & aw_mask(i);
        if (wr && reg_addr_i == wp_reg(i, 1)) wp_data_q[i] <= reg_wdata_i[DW-1:0];
        if (wr && reg_addr_i == wp_reg(i, 2)) wp_ctrl_q[i] <= wp_ctrl_t'(reg_wdata_i[$bits(wp_ctrl_t)-1:0]);
      end
      status_q <= status_d;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == REG_AW'(REG_PC_ADDR)) reg_rdata_o = REG_DW'(pc_addr_q);
    if (reg_addr_i == REG_AW'(REG_PC_CTRL)) reg_rdata_o = REG_DW'(pc_en_q);
    if (reg_addr_i == REG_AW'(REG_STAT))    reg_rdata_o = REG_DW'(status_q);
    for (int i = 0; i < NWP; i++) begin
      if (reg_addr_i == wp_reg(i, 0)) reg_rdata_o = REG_DW'(wp_addr_q[i]);
      if (reg_addr_i == wp_reg(i, 1)) reg_rdata_o = REG_DW'(wp_data_q[i]);
      if (reg_addr_i == wp_reg(i, 2)) reg_rdata_o = REG_DW'(wp_ctrl_q[i]);
    end
  end

  assign pc_addr_o = pc_addr_q;
  assign pc_en_o   = pc_en_q;
  assign wp_addr_o = wp_addr_q;
  assign wp_data_o = wp_data_q;
  assign wp_ctrl_o = wp_ctrl_q;
  assign status_o  = status_q;
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dbg_watch_pkg::*;
#(
  parameter int PC_W   = 16,
  parameter int IDM_AW = 8,
  parameter int SFR_AW = 8,
  parameter int XDM_AW = 16,
  parameter int DW     = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_run_i,
  input  logic              dbg_acc_i,
  input  logic [PC_W-1:0]   pc_i,
  input  logic              pc_valid_i,
  input  logic [IDM_AW-1:0] idm_addr_i,
  input  logic [DW-1:0]     idm_wdata_i,
  input  logic [DW-1:0]     idm_rdata_i,
  input  logic              idm_we_i,
  input  logic              idm_re_i,
  input  logic [SFR_AW-1:0] sfr_addr_i,
  input  logic [DW-1:0]     sfr_wdata_i,
  input  logic [DW-1:0]     sfr_rdata_i,
  input  logic              sfr_we_i,
  input  logic              sfr_re_i,
  input  logic [XDM_AW-1:0] xdm_addr_i,
  input  logic [DW-1:0]     xdm_wdata_i,
  input  logic [DW-1:0]     xdm_rdata_i,
  input  logic              xdm_we_i,
  input  logic              xdm_re_i,
  input  logic              reg_req_i,
  input  logic              reg_we_i,
  input  logic [REG_AW-1:0] reg_addr_i,
  input  logic [REG_DW-1:0] reg_wdata_i,
  output logic [REG_DW-1:0] reg_rdata_o,
  output logic              halt_req_o,
  output logic              cpu_exec_o,
  output logic              dbg_busy_o
);
  localparam int MAX_AW = (XDM_AW > IDM_AW) ? ((XDM_AW > SFR_AW) ? XDM_AW : SFR_AW)
                                            : ((IDM_AW > SFR_AW) ? IDM_AW : SFR_AW);

  logic [PC_W-1:0]            pc_addr;
  logic                       pc_en;
  logic [NWP-1:0][MAX_AW-1:0] wp_addr;
  logic [NWP-1:0][DW-1:0]     wp_data;
  wp_ctrl_t [NWP-1:0]         wp_ctrl;
  logic [NSRC-1:0]            status;
  logic [NSRC-1:0]            src_hit;

  logic [NWP-1:0][MAX_AW-1:0] bus_addr;
  logic [NWP-1:0][DW-1:0]     bus_wdata, bus_rdata;
  logic [NWP-1:0]             bus_we, bus_re;

  assign bus_addr[WP_IDM]  = MAX_AW'(idm_addr_i);
  assign bus_addr[WP_SFR]  = MAX_AW'(sfr_addr_i);
  assign bus_addr[WP_XDM]  = MAX_AW'(xdm_addr_i);
  assign bus_wdata         = {xdm_wdata_i, sfr_wdata_i, idm_wdata_i};
  assign bus_rdata         = {xdm_rdata_i, sfr_rdata_i, idm_rdata_i};
  assign bus_we            = {xdm_we_i, sfr_we_i, idm_we_i};
  assign bus_re            = {xdm_re_i, sfr_re_i, idm_re_i};

  dbg_wp_regs #(
    .PC_W(PC_W), .IDM_AW(IDM_AW), .SFR_AW(SFR_AW), .XDM_AW(XDM_AW), .DW(DW), .MAX_AW(MAX_AW)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .reg_req_i  (reg_req_i),
    .reg_we_i   (reg_we_i),
    .reg_addr_i (reg_addr_i),
    .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o),
    .src_hit_i  (src_hit),
    .pc_addr_o  (pc_addr),
    .pc_en_o    (pc_en),
    .wp_addr_o  (wp_addr),
    .wp_data_o  (wp_data),
    .wp_ctrl_o  (wp_ctrl),
    .status_o   (status)
  );

  dbg_pc_cmp #(.PC_W(PC_W)) u_pc_cmp (
    .cfg_addr_i(pc_addr),
    .cfg_en_i  (pc_en),
    .suppress_i(dbg_acc_i),
    .pc_i      (pc_i),
    .pc_valid_i(pc_valid_i),
    .hit_o     (src_hit[0])
  );

  for (genvar g = 0; g < NWP; g++) begin : g_wp
    dbg_wp_cmp #(.AW(MAX_AW), .DW(DW)) u_cmp (
      .cfg_addr_i (wp_addr[g]),
      .cfg_data_i (wp_data[g]),
      .cfg_i      (wp_ctrl[g]),
      .suppress_i (dbg_acc_i),
      .bus_addr_i (bus_addr[g]),
      .bus_wdata_i(bus_wdata[g]),
      .bus_rdata_i(bus_rdata[g]),
      .bus_we_i   (bus_we[g]),
      .bus_re_i   (bus_re[g]),
      .hit_o      (src_hit[g+1])
    );
  end

  assign halt_req_o = |status;
  assign cpu_exec_o = cpu_run_i & ~halt_req_o;
  assign dbg_busy_o = dbg_acc_i | reg_req_i;
endmodule

// File: rtl/dbg_watch_chk.sv
module dbg_watch_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic halt_i,
  input logic exec_i,
  input logic busy_i,
  input logic run_i,
  input logic dbg_i,
  input logic reg_req_i,
  input logic stat_wr_i,
  input logic clr_all_i,
  input logic any_acc_i
);
  AST_STICKY_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !stat_wr_i |=> halt_i);                           // R9
  AST_CLEAR_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && clr_all_i && !any_acc_i |=> !halt_i);          // R9
  AST_NO_CAUSELESS_HALT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_i && !any_acc_i |=> !halt_i);                         // R10
  AST_DBG_SUPPRESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !halt_i && dbg_i |=> !halt_i);                              // R8
  AST_EXEC_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> !exec_i);                                        // R11
  AST_EXEC_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i && !halt_i |-> exec_i);                               // R11
  AST_BUSY_SEEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_req_i || dbg_i) |-> busy_i);                           // R11
endmodule

bind dbg_watch_unit dbg_watch_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .halt_i   (halt_req_o),
  .exec_i   (cpu_exec_o),
  .busy_i   (dbg_busy_o),
  .run_i    (cpu_run_i),
  .dbg_i    (dbg_acc_i),
  .reg_req_i(reg_req_i),
  .stat_wr_i(reg_req_i && reg_we_i && (reg_addr_i == 4'(dbg_watch_pkg::REG_STAT))),
  .clr_all_i(reg_wdata_i[3:0] == 4'hF),
  .any_acc_i(pc_valid_i | idm_we_i | idm_re_i | sfr_we_i | sfr_re_i | xdm_we_i | xdm_re_i)
);

// File: tb/dbg_watch_unit_tb.sv
`timescale 1ns/1ps
module dbg_watch_unit_tb;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cpu_run_i = 0, dbg_acc_i = 0, pc_valid_i = 0;
  logic [15:0] pc_i = '0;
  logic [7:0]  idm_addr_i = '0, idm_wdata_i = '0, idm_rdata_i = '0;
  logic [7:0]  sfr_addr_i = '0, sfr_wdata_i = '0, sfr_rdata_i = '0;
  logic [15:0] xdm_addr_i = '0;
  logic [7:0]  xdm_wdata_i = '0, xdm_rdata_i = '0;
  logic idm_we_i = 0, idm_re_i = 0, sfr_we_i = 0, sfr_re_i = 0, xdm_we_i = 0, xdm_re_i = 0;
  logic reg_req_i = 0, reg_we_i = 0;
  logic [3:0]  reg_addr_i = '0;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic halt_req_o, cpu_exec_o, dbg_busy_o;

  int checks = 0, failures = 0;
  string cur_req = "R1";
  bit done = 0;

  always #2 clk_i = ~clk_i;

  dbg_watch_unit u_dut (.*);

  // behavioural reference
  logic [15:0] m_pc;
  logic        m_pc_en;
  logic [15:0] m_wa [3];
  logic [7:0]  m_wd [3];
  logic [2:0]  m_wc [3];
  logic [3:0]  m_st;

  function automatic logic [3:0] m_hits();
    logic [3:0] h;
    h = '0;
    if (!dbg_acc_i) begin
      h[0] = m_pc_en && pc_valid_i && (pc_i == m_pc);
      for (int i = 0; i < 3; i++) begin
        logic [15:0] a; logic [7:0] wd, rd; logic we, re, stb; logic [7:0] byt;
        case (i)
          0: begin a = {8'h00, idm_addr_i}; wd = idm_wdata_i; rd = idm_rdata_i; we = idm_we_i; re = idm_re_i; end
          1: begin a = {8'h00, sfr_addr_i}; wd = sfr_wdata_i; rd = sfr_rdata_i; we = sfr_we_i; re = sfr_re_i; end
          default: begin a = xdm_addr_i; wd = xdm_wdata_i; rd = xdm_rdata_i; we = xdm_we_i; re = xdm_re_i; end
        endcase
        stb = m_wc[i][1] ? we : re;
        byt = m_wc[i][1] ? wd : rd;
        h[i+1] = m_wc[i][0] && stb && (a == m_wa[i]) && (!m_wc[i][2] || byt == m_wd[i]);
      end
    end
    return h;
  endfunction

  function automatic logic [15:0] m_read(logic [3:0] a);
    if (a == 0) return m_pc;
    if (a == 1) return {15'b0, m_pc_en};
    if (a == 11) return {12'b0, m_st};
    if (a >= 2 && a <= 10) begin
      int i, k;
      i = (int'(a) - 2) / 3;
      k = (int'(a) - 2) % 3;
      if (k == 0) return m_wa[i];
      if (k == 1) return {8'b0, m_wd[i]};
      return {13'b0, m_wc[i]};
    end
    return 16'h0;
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pc = '0; m_pc_en = 0; m_st = '0;
      for (int i = 0; i < 3; i++) begin m_wa[i] = '0; m_wd[i] = '0; m_wc[i] = '0; end
    end else begin
      logic [3:0] h, c;
      h = m_hits();
      c = '0;
      if (reg_req_i && reg_we_i) begin
        case (reg_addr_i)
          4'd0: m_pc = reg_wdata_i;
          4'd1: m_pc_en = reg_wdata_i[0];
          4'd11: c = reg_wdata_i[3:0];
          default: if (reg_addr_i >= 2 && reg_addr_i <= 10) begin
            int i, k;
            i = (int'(reg_addr_i) - 2) / 3;
            k = (int'(reg_addr_i) - 2) % 3;
            if (k == 0) m_wa[i] = (i < 2) ? (reg_wdata_i & 16'h00FF) : reg_wdata_i;
            else if (k == 1) m_wd[i] = reg_wdata_i[7:0];
            else m_wc[i] = reg_wdata_i[2:0];
          end
        endcase
      end
      m_st = (m_st & ~c) | h;
    end
  end

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk_i) begin
    if (rst_ni && !done) begin
      chk({cur_req, " halt"}, 16'(halt_req_o), 16'(|m_st));
      chk("R11 exec", 16'(cpu_exec_o), 16'(cpu_run_i & ~(|m_st)));
      chk("R11 busy", 16'(dbg_busy_o), 16'(dbg_acc_i | reg_req_i));
      chk({cur_req, " rdata"}, reg_rdata_o, m_read(reg_addr_i));
    end
  end

  task automatic finish_tb();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    finish_tb();
  end

  task automatic nxt(); @(posedge clk_i); #1; endtask

  task automatic reg_wr(logic [3:0] a, logic [15:0] d);
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = a; reg_wdata_i = d;
    nxt();
    reg_req_i = 0; reg_we_i = 0;
  endtask

  task automatic reg_rd(logic [3:0] a, logic [15:0] exp, string req);
    reg_req_i = 1; reg_we_i = 0; reg_addr_i = a;
    @(negedge clk_i);
    chk(req, reg_rdata_o, exp);
    nxt();
    reg_req_i = 0;
  endtask

  task automatic acc(int bus, logic [15:0] a, logic [7:0] wd, logic [7:0] rd, logic we, logic re);
    case (bus)
      0: begin idm_addr_i = a[7:0]; idm_wdata_i = wd; idm_rdata_i = rd; idm_we_i = we; idm_re_i = re; end
      1: begin sfr_addr_i = a[7:0]; sfr_wdata_i = wd; sfr_rdata_i = rd; sfr_we_i = we; sfr_re_i = re; end
      default: begin xdm_addr_i = a; xdm_wdata_i = wd; xdm_rdata_i = rd; xdm_we_i = we; xdm_re_i = re; end
    endcase
    nxt();
    idm_we_i = 0; idm_re_i = 0; sfr_we_i = 0; sfr_re_i = 0; xdm_we_i = 0; xdm_re_i = 0;
  endtask

  task automatic halt_is(logic exp, string req);
    @(negedge clk_i);
    chk(req, 16'(halt_req_o), 16'(exp));
    nxt();
  endtask

  initial begin
    reg_addr_i = 4'd11;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    chk("R1 halt in reset", 16'(halt_req_o), 16'h0);
    chk("R1 status in reset", reg_rdata_o, 16'h0);
    @(posedge clk_i); #1; rst_ni = 1;
    for (int a = 0; a < 12; a++) reg_rd(4'(a), 16'h0, "R1 reg zero");

    cur_req = "R12";
    reg_wr(0, 16'h1234); reg_rd(0, 16'h1234, "R12 pc addr");
    reg_wr(2, 16'hABCD); reg_rd(2, 16'h00CD, "R6 idm addr width");
    reg_wr(5, 16'hFF90); reg_rd(5, 16'h0090, "R6 sfr addr width");
    reg_wr(8, 16'hABCD); reg_rd(8, 16'hABCD, "R6 xdm addr width");
    reg_wr(4, 16'hFFFF); reg_rd(4, 16'h0007, "R12 ctrl bits");
    reg_wr(3, 16'h125A); reg_rd(3, 16'h005A, "R12 data reg");
    reg_wr(4, 16'h0000);
    for (int a = 12; a < 16; a++) reg_rd(4'(a), 16'h0, "R12 unmapped");

    cur_req = "R2";
    reg_wr(0, 16'h0100); reg_wr(1, 16'h0001);
    pc_i = 16'h00FF; pc_valid_i = 1; nxt(); pc_valid_i = 0;
    halt_is(0, "R2 pc miss");
    pc_i = 16'h0100; nxt();
    halt_is(0, "R2 pc no valid");
    pc_valid_i = 1; nxt(); pc_valid_i = 0;
    halt_is(1, "R2 pc hit");
    reg_rd(11, 16'h0001, "R2 status bit0");
    reg_wr(11, 16'h0001); halt_is(0, "R9 clear bit0");

    cur_req = "R3";
    reg_wr(2, 16'h0020); reg_wr(4, 16'h0003);
    acc(0, 16'h20, 8'h00, 8'h00, 0, 1); halt_is(0, "R3 read ignored");
    acc(0, 16'h21, 8'h00, 8'h00, 1, 0); halt_is(0, "R3 other addr");
    acc(0, 16'h20, 8'h77, 8'h00, 1, 0); halt_is(1, "R3 write hit");
    reg_rd(11, 16'h0002, "R3 status bit1");
    reg_wr(11, 16'h000F);

    cur_req = "R4";
    reg_wr(5, 16'h0090); reg_wr(7, 16'h0001);
    acc(1, 16'h90, 8'h00, 8'h00, 1, 0); halt_is(0, "R4 write ignored");
    acc(1, 16'h90, 8'h00, 8'h33, 0, 1); halt_is(1, "R4 read hit");
    reg_rd(11, 16'h0004, "R4 status bit2");
    reg_wr(11, 16'h000F);

    cur_req = "R5";
    reg_wr(3, 16'h005A); reg_wr(4, 16'h0007);
    acc(0, 16'h20, 8'h5B, 8'h5A, 1, 0); halt_is(0, "R5 wrong wdata");
    acc(0, 16'h20, 8'h5A, 8'h00, 1, 0); halt_is(1, "R5 wdata hit");
    reg_wr(11, 16'h000F);
    reg_wr(8, 16'h1234); reg_wr(9, 16'h00C3); reg_wr(10, 16'h0005);
    acc(2, 16'h1234, 8'hC3, 8'h00, 0, 1); halt_is(0, "R5 wrong rdata");
    acc(2, 16'h1234, 8'h00, 8'hC3, 0, 1); halt_is(1, "R5 rdata hit");
    reg_rd(11, 16'h0008, "R5 status bit3");
    reg_wr(11, 16'h000F);

    cur_req = "R6";
    reg_wr(10, 16'h0001);
    acc(2, 16'h0034, 8'h00, 8'h00, 0, 1); halt_is(0, "R6 upper zero");
    acc(2, 16'h1334, 8'h00, 8'h00, 0, 1); halt_is(0, "R6 upper differs");
    acc(2, 16'h1235, 8'h00, 8'h00, 0, 1); halt_is(0, "R6 lower differs");
    acc(2, 16'h1234, 8'h00, 8'h00, 0, 1); halt_is(1, "R6 full match");
    reg_wr(11, 16'h000F);

    cur_req = "R7";
    reg_wr(1, 0); reg_wr(4, 16'h0006); reg_wr(7, 0); reg_wr(10, 16'h0006);
    pc_i = 16'h0100; pc_valid_i = 1;
    acc(0, 16'h20, 8'h5A, 8'h5A, 1, 1);
    pc_valid_i = 0;
    acc(1, 16'h90, 8'h00, 8'h00, 1, 1);
    acc(2, 16'h1234, 8'h00, 8'h00, 1, 1);
    halt_is(0, "R7 disabled");
    reg_rd(11, 16'h0000, "R7 status clear");

    cur_req = "R8";
    reg_wr(1, 1); reg_wr(4, 16'h0003); reg_wr(7, 16'h0001); reg_wr(10, 16'h0001);
    dbg_acc_i = 1; pc_valid_i = 1;
    @(negedge clk_i); chk("R11 busy on dbg", 16'(dbg_busy_o), 16'h1); nxt();
    acc(0, 16'h20, 8'h00, 8'h00, 1, 0);
    acc(1, 16'h90, 8'h00, 8'h00, 0, 1);
    acc(2, 16'h1234, 8'h00, 8'h00, 0, 1);
    dbg_acc_i = 0; pc_valid_i = 0;
    halt_is(0, "R8 suppressed");

    cur_req = "R9";
    cpu_run_i = 1;
    @(negedge clk_i); chk("R11 exec running", 16'(cpu_exec_o), 16'h1); nxt();
    acc(0, 16'h20, 8'h00, 8'h00, 1, 0);
    acc(1, 16'h90, 8'h00, 8'h00, 0, 1);
    @(negedge clk_i); chk("R11 exec halted", 16'(cpu_exec_o), 16'h0); nxt();
    reg_wr(11, 16'h0000); reg_rd(11, 16'h0006, "R9 write zero no effect");
    reg_wr(11, 16'h0009); reg_rd(11, 16'h0006, "R9 other bits kept");
    reg_wr(11, 16'h0002); reg_rd(11, 16'h0004, "R9 per-bit clear");
    reg_req_i = 1; reg_we_i = 1; reg_addr_i = 11; reg_wdata_i = 16'h0004;
    sfr_addr_i = 8'h90; sfr_re_i = 1;
    nxt();
    reg_req_i = 0; reg_we_i = 0; sfr_re_i = 0;
    reg_rd(11, 16'h0004, "R9 set beats clear");
    repeat (5) nxt();
    halt_is(1, "R9 sticky");
    reg_wr(11, 16'h000F); halt_is(0, "R10 halt drops");

    cur_req = "R10";
    reg_wr(4, 16'h0007); reg_wr(3, 16'h0011); reg_wr(9, 16'h0022);
    for (int n = 0; n < 600; n++) begin
      logic [31:0] r;
      r = $urandom;
      dbg_acc_i   = (r[3:0] == 0);
      pc_valid_i  = r[4];
      pc_i        = r[5] ? 16'h0100 : 16'h0101;
      idm_addr_i  = r[6] ? 8'h20 : 8'h22;
      idm_wdata_i = r[7] ? 8'h11 : 8'h10;
      idm_rdata_i = r[8] ? 8'h11 : 8'h12;
      idm_we_i = r[9]; idm_re_i = r[10];
      sfr_addr_i = r[11] ? 8'h90 : 8'h91;
      sfr_we_i = r[12]; sfr_re_i = r[13];
      xdm_addr_i = r[14] ? 16'h1234 : 16'h0234;
      xdm_rdata_i = r[15] ? 8'h22 : 8'h23;
      xdm_we_i = r[16]; xdm_re_i = r[17];
      reg_req_i = (r[20:18] == 0);
      reg_we_i  = r[21];
      reg_addr_i = r[22] ? 4'd11 : 4'(r[26:23]);
      reg_wdata_i = {r[31:27], r[10:0]};
      cpu_run_i = r[30];
      nxt();
    end
    reg_req_i = 0; idm_we_i = 0; idm_re_i = 0; sfr_we_i = 0; sfr_re_i = 0;
    xdm_we_i = 0; xdm_re_i = 0; pc_valid_i = 0; dbg_acc_i = 0;
    nxt();
    finish_tb();
  end
endmodule